// File: doc/BRIEF.md
# Button-selected PWM tone generator

This block produces an audio tone as a one-bit pulse-width-modulated signal that an external amplifier stage smooths into sound. Holding one of four direction buttons chooses a note. Each note has its own divide ratio N. A first divider turns that ratio into a slow tick: one tick every 2·N system clocks. An 8-bit duty counter advances once per tick. Its value is compared against an 8-bit volume input to shape the pulse. Each pulse period therefore spans 256 ticks. The pitch comes from N and the loudness comes from the duty cycle.

The buttons pass through a two-flop synchronizer. When more than one button is held, a fixed priority picks the note. When no button is held, the output stays silent and low. Two further outputs drive the amplifier's gain select and its active-low shutdown, and both are tied high. The block has no data stream. Every pin is a plain level control or output, so no valid/ready handshake applies. The default ratios are 665, 593, 498 and 444 for the up, right, down and left buttons. The ratios are parameters, so a bench can scale them down.

Top module: `tone_gen_top`

## Requirements
- R1: While rst_btn is high at a rising clock edge, audio_out is 0 after that edge and the divider and duty state are cleared, even with a note button held.
- R2: amp_gain and amp_shdn_n are 1 at all times, including during reset.
- R3: With exactly one button held and volume 128, audio_out repeats with a period of 512·N clocks. N is RATIO_UP for btn_up, RATIO_RIGHT for btn_right, RATIO_DOWN for btn_down and RATIO_LEFT for btn_left.
- R4: For a volume v from 1 to 255, audio_out is high for 2·N·v consecutive clocks and low for the remainder of each 512·N clock period.
- R5: With volume 0 and a note button held, audio_out stays 0 continuously.
- R6: With no note button held, audio_out is 0. After all buttons are released, audio_out reads 0 by the third rising edge following the release and stays 0.
- R7: When several buttons are held, the note follows the priority btn_up, then btn_right, then btn_down, then btn_left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_btn | input | 1 | Synchronous reset, active high |
| btn_up | input | 1 | Note button, highest priority |
| btn_right | input | 1 | Note button, second priority |
| btn_down | input | 1 | Note button, third priority |
| btn_left | input | 1 | Note button, lowest priority |
| volume | input | 8 | Duty-cycle level, 0 gives silence |
| audio_out | output | 1 | PWM audio output |
| amp_gain | output | 1 | Amplifier gain select, constant 1 |
| amp_shdn_n | output | 1 | Amplifier shutdown, active low, constant 1 |

## Verification
The assertions assume that every divide ratio is at least 1 and fits the derived counter width. They also assume that the buttons and volume are plain levels that change at most once per clock, so the counter bound and the one-cycle tick spacing follow from the register behaviour alone. The stimulus changes the buttons and the volume only on falling clock edges. After every change it waits a full output period before measuring, so a partial period caused by a note or volume change is never scored. The bench uses scaled ratios of 5, 4, 3 and 2, which keeps all four notes distinguishable while measuring exact clock counts.

// File: rtl/tone_pkg.sv
package tone_pkg;
  typedef enum logic [1:0] {
    NOTE_UP    = 2'd0,
    NOTE_RIGHT = 2'd1,
    NOTE_DOWN  = 2'd2,
    NOTE_LEFT  = 2'd3
  } note_e;

  typedef struct packed {
    logic up;
    logic right;
    logic down;
    logic left;
  } btn_t;

  localparam int DUTY_W = 8;

  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/tone_sync.sv
module tone_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d_in;
      stage2 <= stage1;
    end
  end

  assign d_out = stage2;
endmodule

// File: rtl/tone_select.sv
module tone_select
  import tone_pkg::*;
#(
  parameter int CNT_W   = 10,
  parameter int R_UP    = 665,
  parameter int R_RIGHT = 593,
  parameter int R_DOWN  = 498,
  parameter int R_LEFT  = 444
) (
  input  btn_t             btns,
  output logic             valid,
  output note_e            note,
  output logic [CNT_W-1:0] ratio
);
  always_comb begin
    valid = |btns;
    note  = NOTE_LEFT;
    if (btns.down)  note = NOTE_DOWN;
    if (btns.right) note = NOTE_RIGHT;
    if (btns.up)    note = NOTE_UP;
  end

  always_comb begin
    unique case (note)
      NOTE_UP:    ratio = CNT_W'(R_UP);
      NOTE_RIGHT: ratio = CNT_W'(R_RIGHT);
      NOTE_DOWN:  ratio = CNT_W'(R_DOWN);
      default:    ratio = CNT_W'(R_LEFT);
    endcase
  end
endmodule

// File: rtl/tone_divider.sv
module tone_divider #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid,
  input  logic [CNT_W-1:0] ratio,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] ratio_q;
  logic             phase;
  logic             restart;
  logic             wrap;

  assign restart = !valid || (ratio != ratio_q);
  assign wrap    = (cnt == ratio - 1'b1);
  assign tick    = !restart && wrap && phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      phase   <= 1'b0;
      ratio_q <= '0;
    end else begin
      ratio_q <= ratio;
      if (restart) begin
        cnt   <= '0;
        phase <= 1'b0;
      end else if (wrap) begin
        cnt   <= '0;
        phase <= ~phase;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && ratio == ratio_q) |-> (cnt < ratio));

  // R3
  tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  // R6
  idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !valid |=> (cnt == '0 && !phase));
endmodule

// File: rtl/tone_duty.sv
module tone_duty
  import tone_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic              tick,
  input  logic [DUTY_W-1:0] volume,
  output logic              pwm
);
  logic [DUTY_W-1:0] dcnt;

  always_ff @(posedge clk) begin
    if (rst || !valid) begin
      dcnt <= '0;
      pwm  <= 1'b0;
    end else if (tick) begin
      dcnt <= dcnt + 1'b1;
      pwm  <= (dcnt < volume);
    end
  end

  // R6
  mute_chk: assert property (@(posedge clk) disable iff (rst)
    !valid |=> !pwm);

  // R5
  silent_vol_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && tick && volume == '0) |=> !pwm);

  // R4
  duty_step_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && tick) |=> (dcnt == DUTY_W'($past(dcnt) + 1'b1)));
endmodule

// File: rtl/tone_gen_top.sv
module tone_gen_top
  import tone_pkg::*;
#(
  parameter int RATIO_UP    = 665,
  parameter int RATIO_RIGHT = 593,
  parameter int RATIO_DOWN  = 498,
  parameter int RATIO_LEFT  = 444
) (
  input  logic              clk,
  input  logic              rst_btn,
  input  logic              btn_up,
  input  logic              btn_right,
  input  logic              btn_down,
  input  logic              btn_left,
  input  logic [DUTY_W-1:0] volume,
  output logic              audio_out,
  output logic              amp_gain,
  output logic              amp_shdn_n
);
  localparam int RMAX  = max_of4(RATIO_UP, RATIO_RIGHT, RATIO_DOWN, RATIO_LEFT);
  localparam int CNT_W = (RMAX < 2) ? 1 : $clog2(RMAX + 1);

  btn_t             btn_raw;
  btn_t             btn_s;
  logic             sel_valid;
  note_e            sel_note;
  logic [CNT_W-1:0] sel_ratio;
  logic             tick;

  assign btn_raw = '{up: btn_up, right: btn_right, down: btn_down, left: btn_left};

  tone_sync #(.W(4)) u_sync (
    .clk   (clk),
    .rst   (rst_btn),
    .d_in  (btn_raw),
    .d_out (btn_s)
  );

  tone_select #(
    .CNT_W   (CNT_W),
    .R_UP    (RATIO_UP),
    .R_RIGHT (RATIO_RIGHT),
    .R_DOWN  (RATIO_DOWN),
    .R_LEFT  (RATIO_LEFT)
  ) u_select (
    .btns  (btn_s),
    .valid (sel_valid),
    .note  (sel_note),
    .ratio (sel_ratio)
  );

  tone_divider #(.CNT_W(CNT_W)) u_div (
    .clk   (clk),
    .rst   (rst_btn),
    .valid (sel_valid),
    .ratio (sel_ratio),
    .tick  (tick)
  );

  tone_duty u_duty (
    .clk    (clk),
    .rst    (rst_btn),
    .valid  (sel_valid),
    .tick   (tick),
    .volume (volume),
    .pwm    (audio_out)
  );

  assign amp_gain   = 1'b1;
  assign amp_shdn_n = 1'b1;

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst_btn |=> !audio_out);

  // R7
  prio_up_chk: assert property (@(posedge clk) disable iff (rst_btn)
    btn_s.up |-> (sel_note == NOTE_UP && sel_ratio == CNT_W'(RATIO_UP)));

  // R7
  prio_right_chk: assert property (@(posedge clk) disable iff (rst_btn)
    (btn_s.right && !btn_s.up) |-> (sel_note == NOTE_RIGHT));

  // R7
  prio_down_chk: assert property (@(posedge clk) disable iff (rst_btn)
    (btn_s.down && !btn_s.up && !btn_s.right) |-> (sel_note == NOTE_DOWN));
endmodule

// File: tb/tb_tone_gen_top.sv
module tb_tone_gen_top;
  localparam int NU = 5;
  localparam int NR = 4;
  localparam int ND = 3;
  localparam int NL = 2;

  logic       clk = 1'b0;
  logic       rst_btn;
  logic [3:0] btn;
  logic [7:0] volume;
  logic       audio_out;
  logic       amp_gain;
  logic       amp_shdn_n;

  int checks = 0;
  int fails  = 0;
  int pushed = 0;
  int popped = 0;

  int    exp_period_q[$];
  int    exp_high_q[$];
  string exp_tag_q[$];

  always #4 clk = ~clk;

  tone_gen_top #(
    .RATIO_UP    (NU),
    .RATIO_RIGHT (NR),
    .RATIO_DOWN  (ND),
    .RATIO_LEFT  (NL)
  ) dut (
    .clk        (clk),
    .rst_btn    (rst_btn),
    .btn_up     (btn[3]),
    .btn_right  (btn[2]),
    .btn_down   (btn[1]),
    .btn_left   (btn[0]),
    .volume     (volume),
    .audio_out  (audio_out),
    .amp_gain   (amp_gain),
    .amp_shdn_n (amp_shdn_n)
  );

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Driver: apply a setting, let one full period pass, then queue the expected shape.
  task automatic play(input logic [3:0] b, input logic [7:0] vol, input int n, input string tag);
    @(negedge clk);
    btn    = b;
    volume = vol;
    repeat (512 * n + 16) @(posedge clk);
    exp_period_q.push_back(512 * n);
    exp_high_q.push_back(2 * n * vol);
    exp_tag_q.push_back(tag);
    pushed++;
    wait (popped == pushed);
  endtask

  // Monitor: measure one high/low period starting at a rising output edge.
  initial begin
    forever begin
      int hi;
      int lo;
      int ep;
      int eh;
      string tg;
      wait (exp_period_q.size() > 0);
      ep = exp_period_q[0];
      eh = exp_high_q[0];
      tg = exp_tag_q[0];
      do @(negedge clk); while (audio_out !== 1'b0);
      do @(negedge clk); while (audio_out !== 1'b1);
      hi = 0;
      lo = 0;
      while (audio_out === 1'b1) begin hi++; @(negedge clk); end
      while (audio_out === 1'b0) begin lo++; @(negedge clk); end
      checks++;
      if (hi + lo != ep || hi != eh) begin
        fails++;
        $display("FAIL %s actual period=%0d high=%0d expected period=%0d high=%0d",
                 tg, hi + lo, hi, ep, eh);
      end
      void'(exp_period_q.pop_front());
      void'(exp_high_q.pop_front());
      void'(exp_tag_q.pop_front());
      popped++;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    int highs;
    rst_btn = 1'b1;
    btn     = 4'b1000;
    volume  = 8'd128;
    highs   = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (audio_out !== 1'b0) highs++;
    end
    check(highs == 0, "R1 output low during reset", highs, 0);
    check(amp_gain === 1'b1 && amp_shdn_n === 1'b1, "R2 amplifier controls in reset",
          {amp_gain, amp_shdn_n}, 3);
    btn = 4'b0000;
    @(negedge clk);
    rst_btn = 1'b0;
    @(negedge clk);
    check(audio_out === 1'b0, "R1 output low after reset", audio_out, 0);

    play(4'b1000, 8'd128, NU, "R3 up note");
    play(4'b0100, 8'd128, NR, "R3 right note");
    play(4'b0010, 8'd128, ND, "R3 down note");
    play(4'b0001, 8'd128, NL, "R3 left note");

    play(4'b0001, 8'd1,   NL, "R4 volume 1");
    play(4'b0001, 8'd64,  NL, "R4 volume 64");
    play(4'b0001, 8'd255, NL, "R4 volume 255");

    play(4'b1001, 8'd128, NU, "R7 up over left");
    play(4'b0110, 8'd128, NR, "R7 right over down");
    play(4'b0011, 8'd128, ND, "R7 down over left");

    // R5: volume 0 stays silent for two full periods
    @(negedge clk);
    btn    = 4'b0010;
    volume = 8'd0;
    repeat (64) @(negedge clk);
    highs = 0;
    for (int i = 0; i < 2 * 512 * ND; i++) begin
      @(negedge clk);
      if (audio_out !== 1'b0) highs++;
    end
    check(highs == 0, "R5 volume zero silent", highs, 0);

    // R6: release while the output is high
    @(negedge clk);
    btn    = 4'b1000;
    volume = 8'd255;
    repeat (512 * NU + 16) @(negedge clk);
    do @(negedge clk); while (audio_out !== 1'b1);
    btn = 4'b0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(audio_out === 1'b0, "R6 output low three edges after release", audio_out, 0);
    highs = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (audio_out !== 1'b0) highs++;
    end
    check(highs == 0, "R6 output stays low with no button", highs, 0);
    check(amp_gain === 1'b1 && amp_shdn_n === 1'b1, "R2 amplifier controls in operation",
          {amp_gain, amp_shdn_n}, 3);

    summary();
    $finish;
  end
endmodule